// File: doc/BRIEF.md
# Dual-Register Logic Cell with Steerable Sum Terms

This block is a cycle-accurate behavioural model of one output logic cell in a sum-of-products programmable array. The product-term array lies outside the block. It delivers twelve already-evaluated product-term bits, grouped into three sum terms of four terms each. It also delivers five control terms per cell: one asynchronous clear and one clock for each of two flip-flops, plus an output enable. The cell steers its three sum terms between the pin and the two flip-flops. A path can collect four, eight or twelve terms.

Both flip-flops are modelled on a single system clock. A flip-flop loads when its own clock term is seen to rise between two system edges, so the two registers can follow unrelated clock terms. A preset line shared with neighbouring cells sets a register on its clock edge. The cell returns true and complement feedback for each register and for the pin. The pin feedback shows the driven level when the output is enabled and the external level when it is not. Configuration inputs are captured while reset is held and stay frozen afterwards.

Top module: `plcell_top`

## Requirements
- R1: `prodTerms` holds three groups of four bits: sumA = OR of bits [3:0], sumB = OR of bits [7:4], sumC = OR of bits [11:8]. With `cfgRegOut`=0, the pin core follows the inputs combinationally. `cfgCombWidth` 0 gives sumA, 1 gives sumA|sumB, and 2 or 3 gives sumA|sumB|sumC.
- R2: With `cfgRegOut`=1, register 1 loads sumA|sumB, plus sumC when `cfgMergeD2`=1. Register 1 then drives the pin core.
- R3: With `cfgRegOut`=0, register 1 loads sumB and register 2 loads sumC. In both modes register 2 loads sumC.
- R4: A register loads only at a system clock edge where its clock term is 1 and was 0 at the previous edge. The new value shows after that edge. Each register follows only its own clock term. A term held high causes no further load.
- R5: A clear term that is 1 at a system edge forces its register to 0 at that edge. It overrides both the preset and a clock rise.
- R6: `syncPreset` at 1 on a register's clock rise loads 1 instead of its data input.
- R7: `cfgActiveHigh`=1 drives the core on `pinOut` unchanged, and 0 drives its inverse.
- R8: `pinOe` equals `oeTerm`. `fbPin` is `pinOut` when `oeTerm`=1 and `pinIn` otherwise.
- R9: `fbQ1N`, `fbQ2N` and `fbPinN` are always the complements of `fbQ1`, `fbQ2` and `fbPin`.
- R10: During reset, both registers are 0, and in registered mode `pinOut` equals the inverse of `cfgActiveHigh`.
- R11: The configuration inputs are captured only while `rstN` is low. Changes after reset release do not affect the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all terms |
| rstN | input | 1 | Active-low reset, also captures configuration |
| prodTerms | input | 12 | Evaluated product terms, three groups of four |
| arTerm1 | input | 1 | Clear term for register 1 |
| arTerm2 | input | 1 | Clear term for register 2 |
| clkTerm1 | input | 1 | Clock term for register 1 |
| clkTerm2 | input | 1 | Clock term for register 2 |
| oeTerm | input | 1 | Output enable term |
| syncPreset | input | 1 | Shared synchronous preset |
| pinIn | input | 1 | External pin level when not driven |
| cfgRegOut | input | 1 | 1: registered pin, 0: combinatorial |
| cfgMergeD2 | input | 1 | Registered mode: add sumC to register 1 |
| cfgCombWidth | input | 2 | Combinatorial width select |
| cfgActiveHigh | input | 1 | Output polarity |
| pinOut | output | 1 | Pin drive value |
| pinOe | output | 1 | Pin drive enable |
| fbQ2 | output | 1 | Register 2 true feedback |
| fbQ2N | output | 1 | Register 2 complement feedback |
| fbQ1 | output | 1 | Register 1 true feedback |
| fbQ1N | output | 1 | Register 1 complement feedback |
| fbPin | output | 1 | Pin true feedback |
| fbPinN | output | 1 | Pin complement feedback |

## Verification
Every cycle, the in-line assertions check four things: the effect of a clear strobe, the effect of a preset load, that a register holds its value when it has no strobe, and that the captured configuration stays frozen after reset. The steering of sum terms to each path can only be shown by scenarios: the bench runs all 32 configurations against a reference sum-of-products function. The same applies to the priority order of clear, preset and data, and to clock-edge independence. Scenarios also cover the pin feedback with the output disabled and the outputs' indifference to configuration changes after reset.

// File: rtl/plcell_pkg.sv
package plcell_pkg;
  typedef struct packed {
    logic       regOut;
    logic       mergeD2;
    logic [1:0] combWidth;
    logic       activeHigh;
  } cellCfg_t;

  typedef struct packed {
    logic clear1;
    logic clear2;
    logic load1;
    logic load2;
    logic preset;
  } cellStrobe_t;
endpackage

// File: rtl/plcell_control.sv
module plcell_control
  import plcell_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        arTerm1,
  input  logic        arTerm2,
  input  logic        clkTerm1,
  input  logic        clkTerm2,
  input  logic        syncPreset,
  input  cellCfg_t    cfgIn,
  output cellStrobe_t strobe,
  output cellCfg_t    cfgHeld
);
  logic clkPrev1, clkPrev2;
  logic rise1, rise2;

  // previous clock-term levels, sampled every edge so no edge appears at reset release
  always_ff @(posedge clk) begin
    clkPrev1 <= clkTerm1;
    clkPrev2 <= clkTerm2;
  end

  // configuration is transparent only during reset
  always_ff @(posedge clk) begin
    if (!rstN) cfgHeld <= cfgIn;
  end

  assign rise1 = clkTerm1 & ~clkPrev1;
  assign rise2 = clkTerm2 & ~clkPrev2;

  always_comb begin
    strobe.clear1 = arTerm1;
    strobe.clear2 = arTerm2;
    strobe.load1  = rise1 & ~arTerm1;
    strobe.load2  = rise2 & ~arTerm2;
    strobe.preset = syncPreset;
  end

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(cfgHeld));
endmodule

// File: rtl/plcell_datapath.sv
module plcell_datapath
  import plcell_pkg::*;
#(
  parameter int TERMS_PER_SUM = 4,
  localparam int SUM_COUNT = 3,
  localparam int PT_WIDTH  = SUM_COUNT * TERMS_PER_SUM
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PT_WIDTH-1:0] prodTerms,
  input  logic                oeTerm,
  input  logic                pinIn,
  input  cellStrobe_t         strobe,
  input  cellCfg_t            cfg,
  output logic                pinOut,
  output logic                pinOe,
  output logic                q1,
  output logic                q2,
  output logic                pinFb
);
  logic [SUM_COUNT-1:0] sumVal;
  logic sumA, sumB, sumC;
  logic d1, d2, combCore, core;

  for (genvar g = 0; g < SUM_COUNT; g++) begin : gSum
    assign sumVal[g] = |prodTerms[g*TERMS_PER_SUM +: TERMS_PER_SUM];
  end

  assign sumA = sumVal[0];
  assign sumB = sumVal[1];
  assign sumC = sumVal[2];

  // steering of the three sum terms
  always_comb begin
    d2 = sumC;
    if (cfg.regOut) d1 = sumA | sumB | (cfg.mergeD2 & sumC);
    else            d1 = sumB;
    case (cfg.combWidth)
      2'd0:    combCore = sumA;
      2'd1:    combCore = sumA | sumB;
      default: combCore = sumA | sumB | sumC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              q1 <= 1'b0;
    else if (strobe.clear1) q1 <= 1'b0;
    else if (strobe.load1)  q1 <= strobe.preset ? 1'b1 : d1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              q2 <= 1'b0;
    else if (strobe.clear2) q2 <= 1'b0;
    else if (strobe.load2)  q2 <= strobe.preset ? 1'b1 : d2;
  end

  assign core   = cfg.regOut ? q1 : combCore;
  assign pinOut = cfg.activeHigh ? core : ~core;
  assign pinOe  = oeTerm;
  assign pinFb  = oeTerm ? pinOut : pinIn;

  assert_clear_q1_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear1 |=> !q1);
  assert_clear_q2_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear2 |=> !q2);
  assert_preset_q1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load1 && strobe.preset) |=> q1);
  assert_preset_q2_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load2 && strobe.preset) |=> q2);
  assert_hold_q1_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear1 && !strobe.load1) |=> $stable(q1));
  assert_hold_q2_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear2 && !strobe.load2) |=> $stable(q2));
endmodule

// File: rtl/plcell_top.sv
module plcell_top
  import plcell_pkg::*;
#(
  parameter int TERMS_PER_SUM = 4,
  localparam int PT_WIDTH = 3 * TERMS_PER_SUM
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PT_WIDTH-1:0] prodTerms,
  input  logic                arTerm1,
  input  logic                arTerm2,
  input  logic                clkTerm1,
  input  logic                clkTerm2,
  input  logic                oeTerm,
  input  logic                syncPreset,
  input  logic                pinIn,
  input  logic                cfgRegOut,
  input  logic                cfgMergeD2,
  input  logic [1:0]          cfgCombWidth,
  input  logic                cfgActiveHigh,
  output logic                pinOut,
  output logic                pinOe,
  output logic                fbQ2,
  output logic                fbQ2N,
  output logic                fbQ1,
  output logic                fbQ1N,
  output logic                fbPin,
  output logic                fbPinN
);
  cellCfg_t    cfgIn, cfgHeld;
  cellStrobe_t strobe;
  logic        q1, q2, pinFb;

  assign cfgIn = '{regOut: cfgRegOut, mergeD2: cfgMergeD2,
                   combWidth: cfgCombWidth, activeHigh: cfgActiveHigh};

  plcell_control i_control (
    .clk(clk), .rstN(rstN), .arTerm1(arTerm1), .arTerm2(arTerm2),
    .clkTerm1(clkTerm1), .clkTerm2(clkTerm2), .syncPreset(syncPreset),
    .cfgIn(cfgIn), .strobe(strobe), .cfgHeld(cfgHeld)
  );

  plcell_datapath #(.TERMS_PER_SUM(TERMS_PER_SUM)) i_datapath (
    .clk(clk), .rstN(rstN), .prodTerms(prodTerms), .oeTerm(oeTerm),
    .pinIn(pinIn), .strobe(strobe), .cfg(cfgHeld), .pinOut(pinOut),
    .pinOe(pinOe), .q1(q1), .q2(q2), .pinFb(pinFb)
  );

  assign fbQ1   = q1;
  assign fbQ1N  = ~q1;
  assign fbQ2   = q2;
  assign fbQ2N  = ~q2;
  assign fbPin  = pinFb;
  assign fbPinN = ~pinFb;
endmodule

// File: tb/test_plcell_top.sv
module test_plcell_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] prodTerms = '0;
  logic arTerm1 = 0, arTerm2 = 0, clkTerm1 = 0, clkTerm2 = 0;
  logic oeTerm = 1, syncPreset = 0, pinIn = 0;
  logic cfgRegOut = 1, cfgMergeD2 = 0, cfgActiveHigh = 1;
  logic [1:0] cfgCombWidth = 0;
  logic pinOut, pinOe, fbQ2, fbQ2N, fbQ1, fbQ1N, fbPin, fbPinN;
  int total = 0, bad = 0;
  bit finished = 0;

  localparam logic [11:0] PATS [8] = '{
    12'h000, 12'h001, 12'h020, 12'h400,
    12'h860, 12'h0F0, 12'h800, 12'h108
  };

  plcell_top i_plcell_top (.*);

  always #10 clk = ~clk;

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; clkTerm1 = 0; clkTerm2 = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  task automatic pulse(logic b1, logic b2);
    @(negedge clk); clkTerm1 = b1; clkTerm2 = b2;
    @(negedge clk); clkTerm1 = 0; clkTerm2 = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // table walk over all configurations against a reference model
    for (int c = 0; c < 32; c++) begin
      logic ro, mg, ah; logic [1:0] cw;
      ro = c[0]; mg = c[1]; cw = c[3:2]; ah = c[4];
      cfgRegOut = ro; cfgMergeD2 = mg; cfgCombWidth = cw; cfgActiveHigh = ah;
      doReset();
      check("R10 q1 after reset", fbQ1, 1'b0);
      check("R10 q2 after reset", fbQ2, 1'b0);
      if (ro) check("R10 pin after reset", pinOut, ~ah);
      for (int p = 0; p < 8; p++) begin
        logic sa, sb, sc, comb, e1, e2;
        sa = |PATS[p][3:0]; sb = |PATS[p][7:4]; sc = |PATS[p][11:8];
        comb = (cw == 0) ? sa : (cw == 1) ? (sa | sb) : (sa | sb | sc);
        e1 = ro ? (sa | sb | (mg & sc)) : sb;
        e2 = sc;
        @(negedge clk); prodTerms = PATS[p];
        @(negedge clk);
        if (!ro) check("R1 R7 comb pin", pinOut, ah ? comb : ~comb);
        pulse(1, 1);
        check(ro ? "R2 q1 data" : "R3 q1 data", fbQ1, e1);
        check("R3 q2 data", fbQ2, e2);
        check("R9 q1 complement", fbQ1N, ~e1);
        check("R9 q2 complement", fbQ2N, ~e2);
        if (ro) check("R2 R7 reg pin", pinOut, ah ? e1 : ~e1);
      end
    end

    // directed: registered, active high, no merge
    cfgRegOut = 1; cfgMergeD2 = 0; cfgCombWidth = 0; cfgActiveHigh = 1;
    doReset();
    prodTerms = 12'hFFF; pulse(1, 1);
    check("R2 load ones", fbQ1, 1'b1);
    // clear beats clock rise and preset
    arTerm1 = 1; syncPreset = 1; prodTerms = 12'h000; pulse(1, 1);
    check("R5 clear over preset", fbQ1, 1'b0);
    check("R6 preset on q2", fbQ2, 1'b1);
    arTerm1 = 0;
    // preset beats data
    pulse(1, 0);
    check("R6 preset over data", fbQ1, 1'b1);
    syncPreset = 0;
    // only register 2 clocked
    pulse(0, 1);
    check("R4 q2 own clock", fbQ2, 1'b0);
    check("R4 q1 untouched", fbQ1, 1'b1);
    // held clock term: no second load
    @(negedge clk); clkTerm1 = 1; prodTerms = 12'h000;
    @(negedge clk);
    check("R4 load on rise", fbQ1, 1'b0);
    prodTerms = 12'h00F;
    @(negedge clk); @(negedge clk);
    check("R4 no load while held", fbQ1, 1'b0);
    clkTerm1 = 0;
    // preset without clock edge
    syncPreset = 1; @(negedge clk); @(negedge clk);
    check("R6 preset needs edge", fbQ1, 1'b0);
    syncPreset = 0;
    // clear term without clock
    prodTerms = 12'hFFF; pulse(1, 1);
    arTerm2 = 1; @(negedge clk); @(negedge clk);
    check("R5 clear without clock", fbQ2, 1'b0);
    check("R5 other reg kept", fbQ1, 1'b1);
    arTerm2 = 0;
    // configuration change after reset ignored
    cfgRegOut = 0; cfgActiveHigh = 0; prodTerms = 12'h000;
    @(negedge clk); @(negedge clk);
    check("R11 cfg frozen pin", pinOut, 1'b1);
    // enable and pin feedback
    oeTerm = 1; pinIn = 0; @(negedge clk);
    check("R8 oe follows", pinOe, 1'b1);
    check("R8 fb driven", fbPin, 1'b1);
    check("R9 pin complement", fbPinN, 1'b0);
    oeTerm = 0; pinIn = 0; @(negedge clk);
    check("R8 oe off", pinOe, 1'b0);
    check("R8 fb external", fbPin, 1'b0);
    check("R9 pin complement off", fbPinN, 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule